// File: doc/BRIEF.md
# Age-Ordered Operand-Read Schedule Queue

This block sits between the stage that lists ready wave instructions and the stage that dispatches them to execution. It keeps one queue per execution resource. Each entry in a queue is a wave instruction whose register-file operands are being read. Every cycle each resource may offer one candidate wave. The block admits that candidate only when the register files accept its read, when the wave does not already sit in some queue, and when the target queue has room. An admitted entry starts as operands-busy. It turns operands-ready once both register files report that its reads are complete.

Each cycle every queue hands the oldest operands-ready entry whose wave is cleared for dispatch to its dispatch output, and that entry leaves the queue. An entry that later loses arbitration downstream comes back through the re-insert port. It is placed by its age tag rather than at the tail, and it is already operands-ready. A membership vector, one bit per wave slot, records which waves hold an entry. Only an explicit release clears a bit, so a wave is never admitted twice and cannot run out of order.

Top module: `opq_sched`

## Requirements
- R1: After reset every queue count is 0, no dispatch output is valid and no wave slot is marked as a member.
- R2: A candidate is admitted only if its scalar-file grant is high and, for a non-scalar candidate, its vector-file grant is also high. A scalar candidate is admitted with the vector-file grant low. The `admit` output is combinational in the same cycle, and the queue count rises at the next edge.
- R3: A candidate whose slot bit in `member` is 1 is not admitted on any resource. An admission sets that slot's `member` bit from the next cycle on.
- R4: When several resources offer the same slot in one cycle, only one admits it. The memory resources (indices MEM_BASE to MEM_BASE+NMEM-1) win over the others, and among resources of the same kind the lower index wins.
- R5: Admission is refused when the queue holds DEPTH entries. It is also refused when the queue holds DEPTH-1 entries and a re-insert arrives for that queue in the same cycle.
- R6: A new entry is operands-busy. It becomes operands-ready in a cycle where `srf_done[slot]` is 1 and, unless the entry is scalar, `vrf_done[slot]` is also 1. Once ready it stays ready.
- R7: Each cycle each queue selects its oldest operands-ready entry whose `disp_ok[slot]` is 1, skipping older entries that do not qualify. The selection appears on the dispatch outputs after the next clock edge, and the entry is removed from the queue.
- R8: A re-inserted entry is operands-ready. It is placed in front of the first entry whose age tag is greater than or equal to its own, or at the tail if no such entry exists.
- R9: A `member` bit is cleared only in the cycle after `release_vld` names that slot. Dispatch leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_vld | input | NRES | Candidate offered per resource |
| cand_slot | input | NRES*SW | Wave slot of each candidate |
| cand_age | input | NRES*AW | Age tag of each candidate (smaller is older) |
| cand_scalar | input | NRES | Candidate is a scalar instruction |
| vrf_gnt | input | NRES | Vector register file accepts the read |
| srf_gnt | input | NRES | Scalar register file accepts the read |
| reins_vld | input | NRES | Re-insert an entry into this resource's queue |
| reins_slot | input | NRES*SW | Slot of the re-inserted entry |
| reins_age | input | NRES*AW | Age tag of the re-inserted entry |
| reins_scalar | input | NRES | Re-inserted entry is scalar |
| vrf_done | input | NSLOT | Vector-file operand reads complete, per slot |
| srf_done | input | NSLOT | Scalar-file operand reads complete, per slot |
| disp_ok | input | NSLOT | Execution readiness per slot |
| release_vld | input | 1 | Clear the membership of one slot |
| release_slot | input | SW | Slot to clear |
| admit | output | NRES | Candidate admitted this cycle |
| disp_vld | output | NRES | Dispatch output valid |
| disp_slot | output | NRES*SW | Dispatched slot |
| disp_age | output | NRES*AW | Dispatched age tag |
| disp_scalar | output | NRES | Dispatched entry is scalar |
| q_count | output | NRES*CW | Entries held per queue |
| member | output | NSLOT | Slots that hold an entry |

## Verification
The assertions assume that a re-insert never targets a full queue and that a released slot is not re-inserted afterwards. The count-step check also assumes at most one re-insert and one admission per queue per cycle. The stimulus meets these assumptions in the following ways:
- Every scenario starts from reset.
- Queues are filled to a known count before any re-insert.
- Re-inserts use slots that are not in use elsewhere.
- A release is issued only after the released wave has left its queue through dispatch.

// File: rtl/opq_pkg.sv
package opq_pkg;

    typedef enum logic {
        OPS_BUSY  = 1'b0,
        OPS_READY = 1'b1
    } opnd_st_e;

    // memory resources are served in the first pass
    function automatic logic is_mem_res(input int r, input int base, input int n);
        return (r >= base) && (r < base + n);
    endfunction

endpackage

// File: rtl/opq_admit.sv
module opq_admit
    import opq_pkg::*;
#(
    parameter int NRES     = 3,
    parameter int NSLOT    = 8,
    parameter int MEM_BASE = 1,
    parameter int NMEM     = 1,
    parameter int SW       = $clog2(NSLOT)
) (
    input  logic [NRES-1:0]    cand_vld,
    input  logic [NRES*SW-1:0] cand_slot,
    input  logic [NRES-1:0]    cand_scalar,
    input  logic [NRES-1:0]    vrf_gnt,
    input  logic [NRES-1:0]    srf_gnt,
    input  logic [NRES-1:0]    room,
    input  logic [NSLOT-1:0]   member_q,
    output logic [NRES-1:0]    admit
);

    logic [NSLOT-1:0] claimed;
    logic [SW-1:0]    sl;
    logic             rf_ok;

    always_comb begin
        claimed = '0;
        admit   = '0;
        sl      = '0;
        rf_ok   = 1'b0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int r = 0; r < NRES; r++) begin
                if ((pass == 0) == is_mem_res(r, MEM_BASE, NMEM)) begin
                    sl    = cand_slot[r*SW +: SW];
                    rf_ok = srf_gnt[r] && (cand_scalar[r] || vrf_gnt[r]);
                    if (cand_vld[r] && rf_ok && room[r] &&
                        !member_q[sl] && !claimed[sl]) begin
                        admit[r]    = 1'b1;
                        claimed[sl] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/opq_member.sv
module opq_member #(
    parameter int NRES  = 3,
    parameter int NSLOT = 8,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NRES-1:0]    admit,
    input  logic [NRES*SW-1:0] cand_slot,
    input  logic               release_vld,
    input  logic [SW-1:0]      release_slot,
    output logic [NSLOT-1:0]   member
);

    typedef struct packed {
        logic [NSLOT-1:0] bits;
    } mem_st_t;

    mem_st_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (release_vld) begin
            m_d.bits[release_slot] = 1'b0;
        end
        for (int r = 0; r < NRES; r++) begin
            if (admit[r]) begin
                m_d.bits[cand_slot[r*SW +: SW]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign member = m_q.bits;

endmodule

// File: rtl/opq_queue.sv
module opq_queue
    import opq_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int SW    = $clog2(NSLOT),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reins_vld,
    input  logic [SW-1:0]    reins_slot,
    input  logic [AW-1:0]    reins_age,
    input  logic             reins_scalar,
    input  logic             push,
    input  logic [SW-1:0]    push_slot,
    input  logic [AW-1:0]    push_age,
    input  logic             push_scalar,
    input  logic [NSLOT-1:0] vrf_done,
    input  logic [NSLOT-1:0] srf_done,
    input  logic [NSLOT-1:0] disp_ok,
    output logic             has_room,
    output logic [CW-1:0]    count,
    output logic             disp_vld,
    output logic [SW-1:0]    disp_slot,
    output logic [AW-1:0]    disp_age,
    output logic             disp_scalar
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    typedef struct packed {
        logic [SW-1:0] slot;
        logic [AW-1:0] age;
        logic          scalar;
        opnd_st_e      st;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [CW-1:0]    cnt;
        logic             dv;
        logic [SW-1:0]    ds;
        logic [AW-1:0]    da;
        logic             dsc;
    } qst_t;

    qst_t q_d, q_q;
    int   pos_c;
    int   sel_c;
    logic hit_c;

    // room for a push after any re-insert this cycle
    assign has_room = reins_vld ? (q_q.cnt < FULL_C - 1'b1) : (q_q.cnt < FULL_C);

    always_comb begin
        q_d    = q_q;
        q_d.dv = 1'b0;
        pos_c  = int'(q_q.cnt);
        sel_c  = 0;
        hit_c  = 1'b0;

        // age-ordered re-insert, already operands-ready
        if (reins_vld && q_q.cnt < FULL_C) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!hit_c && i < int'(q_q.cnt) && q_q.ent[i].age >= reins_age) begin
                    pos_c = i;
                    hit_c = 1'b1;
                end
            end
            for (int i = DEPTH - 1; i > 0; i--) begin
                if (i > pos_c) begin
                    q_d.ent[i] = q_d.ent[i-1];
                end
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (i == pos_c) begin
                    q_d.ent[i] = ent_t'{slot: reins_slot, age: reins_age,
                                        scalar: reins_scalar, st: OPS_READY};
                end
            end
            q_d.cnt = q_d.cnt + 1'b1;
        end

        // admission appends at the tail, operands-busy
        if (push && q_d.cnt < FULL_C) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == int'(q_d.cnt)) begin
                    q_d.ent[i] = ent_t'{slot: push_slot, age: push_age,
                                        scalar: push_scalar, st: OPS_BUSY};
                end
            end
            q_d.cnt = q_d.cnt + 1'b1;
        end

        // operand-read completion
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(q_d.cnt) && q_d.ent[i].st == OPS_BUSY &&
                srf_done[q_d.ent[i].slot] &&
                (q_d.ent[i].scalar || vrf_done[q_d.ent[i].slot])) begin
                q_d.ent[i].st = OPS_READY;
            end
        end

        // oldest qualifying entry goes to dispatch
        hit_c = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!hit_c && i < int'(q_d.cnt) && q_d.ent[i].st == OPS_READY &&
                disp_ok[q_d.ent[i].slot]) begin
                sel_c = i;
                hit_c = 1'b1;
            end
        end
        if (hit_c) begin
            q_d.dv = 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                if (i == sel_c) begin
                    q_d.ds  = q_d.ent[i].slot;
                    q_d.da  = q_d.ent[i].age;
                    q_d.dsc = q_d.ent[i].scalar;
                end
            end
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= sel_c) begin
                    q_d.ent[i] = q_d.ent[i+1];
                end
            end
            q_d.ent[DEPTH-1] = '0;
            q_d.cnt = q_d.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign count       = q_q.cnt;
    assign disp_vld    = q_q.dv;
    assign disp_slot   = q_q.ds;
    assign disp_age    = q_q.da;
    assign disp_scalar = q_q.dsc;

endmodule

// File: rtl/opq_sched.sv
module opq_sched
    import opq_pkg::*;
#(
    parameter int NRES     = 3,
    parameter int NSLOT    = 8,
    parameter int DEPTH    = 8,
    parameter int AW       = 8,
    parameter int MEM_BASE = 1,
    parameter int NMEM     = 1,
    parameter int SW       = $clog2(NSLOT),
    parameter int CW       = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NRES-1:0]    cand_vld,
    input  logic [NRES*SW-1:0] cand_slot,
    input  logic [NRES*AW-1:0] cand_age,
    input  logic [NRES-1:0]    cand_scalar,
    input  logic [NRES-1:0]    vrf_gnt,
    input  logic [NRES-1:0]    srf_gnt,
    input  logic [NRES-1:0]    reins_vld,
    input  logic [NRES*SW-1:0] reins_slot,
    input  logic [NRES*AW-1:0] reins_age,
    input  logic [NRES-1:0]    reins_scalar,
    input  logic [NSLOT-1:0]   vrf_done,
    input  logic [NSLOT-1:0]   srf_done,
    input  logic [NSLOT-1:0]   disp_ok,
    input  logic               release_vld,
    input  logic [SW-1:0]      release_slot,
    output logic [NRES-1:0]    admit,
    output logic [NRES-1:0]    disp_vld,
    output logic [NRES*SW-1:0] disp_slot,
    output logic [NRES*AW-1:0] disp_age,
    output logic [NRES-1:0]    disp_scalar,
    output logic [NRES*CW-1:0] q_count,
    output logic [NSLOT-1:0]   member
);

    logic [NRES-1:0] room;

    opq_admit #(
        .NRES(NRES), .NSLOT(NSLOT), .MEM_BASE(MEM_BASE), .NMEM(NMEM), .SW(SW)
    ) u_admit (
        .cand_vld(cand_vld), .cand_slot(cand_slot), .cand_scalar(cand_scalar),
        .vrf_gnt(vrf_gnt), .srf_gnt(srf_gnt), .room(room),
        .member_q(member), .admit(admit)
    );

    opq_member #(
        .NRES(NRES), .NSLOT(NSLOT), .SW(SW)
    ) u_member (
        .clk(clk), .rst_n(rst_n), .admit(admit), .cand_slot(cand_slot),
        .release_vld(release_vld), .release_slot(release_slot), .member(member)
    );

    for (genvar r = 0; r < NRES; r++) begin : g_res
        opq_queue #(
            .NSLOT(NSLOT), .DEPTH(DEPTH), .AW(AW), .SW(SW), .CW(CW)
        ) u_queue (
            .clk(clk), .rst_n(rst_n),
            .reins_vld(reins_vld[r]),
            .reins_slot(reins_slot[r*SW +: SW]),
            .reins_age(reins_age[r*AW +: AW]),
            .reins_scalar(reins_scalar[r]),
            .push(admit[r]),
            .push_slot(cand_slot[r*SW +: SW]),
            .push_age(cand_age[r*AW +: AW]),
            .push_scalar(cand_scalar[r]),
            .vrf_done(vrf_done), .srf_done(srf_done), .disp_ok(disp_ok),
            .has_room(room[r]),
            .count(q_count[r*CW +: CW]),
            .disp_vld(disp_vld[r]),
            .disp_slot(disp_slot[r*SW +: SW]),
            .disp_age(disp_age[r*AW +: AW]),
            .disp_scalar(disp_scalar[r])
        );
    end

endmodule

// File: rtl/opq_sched_chk.sv
module opq_sched_chk #(
    parameter int NRES  = 3,
    parameter int NSLOT = 8,
    parameter int DEPTH = 8,
    parameter int SW    = 3,
    parameter int CW    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NRES-1:0]    cand_vld,
    input logic [NRES*SW-1:0] cand_slot,
    input logic [NRES-1:0]    reins_vld,
    input logic               release_vld,
    input logic [SW-1:0]      release_slot,
    input logic [NRES-1:0]    admit,
    input logic [NRES*CW-1:0] q_count,
    input logic [NSLOT-1:0]   member
);

    logic [SW-1:0]              slot_q [NRES];
    logic [NSLOT-1:0][NRES-1:0] hit;

    always_ff @(posedge clk) begin
        for (int r = 0; r < NRES; r++) begin
            slot_q[r] <= cand_slot[r*SW +: SW];
        end
    end

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            for (int r = 0; r < NRES; r++) begin
                hit[i][r] = admit[r] && (int'(cand_slot[r*SW +: SW]) == i);
            end
        end
    end

    for (genvar r = 0; r < NRES; r++) begin : g_r
        a_r3_admit_sets_member: assert property (@(posedge clk) disable iff (!rst_n)
            admit[r] |=> member[slot_q[r]]);
        a_r3_member_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            (cand_vld[r] && member[cand_slot[r*SW +: SW]]) |-> !admit[r]);
        a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
            int'(q_count[r*CW +: CW]) <= DEPTH);
        a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(q_count[r*CW +: CW]) <= int'($past(q_count[r*CW +: CW])) + 2) &&
            (int'(q_count[r*CW +: CW]) + 1 >= int'($past(q_count[r*CW +: CW]))));
        a_r8_reins_room: assert property (@(posedge clk) disable iff (!rst_n)
            reins_vld[r] |-> int'(q_count[r*CW +: CW]) < DEPTH);
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_s
        a_r4_one_admit_per_slot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hit[i]));
        a_r9_clear_by_release: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(member[i]) |-> $past(release_vld && int'(release_slot) == i));
    end

endmodule

bind opq_sched opq_sched_chk #(
    .NRES(NRES), .NSLOT(NSLOT), .DEPTH(DEPTH), .SW(SW), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cand_vld(cand_vld), .cand_slot(cand_slot),
    .reins_vld(reins_vld), .release_vld(release_vld), .release_slot(release_slot),
    .admit(admit), .q_count(q_count), .member(member)
);

// File: tb/test_opq_sched.sv
`timescale 1ns/1ps
module test_opq_sched;

    localparam int NRES = 3, NSLOT = 8, DEPTH = 4, AW = 6;
    localparam int SW = 3, CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NRES-1:0]    cand_vld, cand_scalar, vrf_gnt, srf_gnt, reins_vld, reins_scalar;
    logic [NRES*SW-1:0] cand_slot, reins_slot;
    logic [NRES*AW-1:0] cand_age, reins_age;
    logic [NSLOT-1:0]   vrf_done, srf_done, disp_ok;
    logic               release_vld;
    logic [SW-1:0]      release_slot;
    logic [NRES-1:0]    admit, disp_vld, disp_scalar;
    logic [NRES*SW-1:0] disp_slot;
    logic [NRES*AW-1:0] disp_age;
    logic [NRES*CW-1:0] q_count;
    logic [NSLOT-1:0]   member;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    opq_sched #(
        .NRES(NRES), .NSLOT(NSLOT), .DEPTH(DEPTH), .AW(AW), .MEM_BASE(1), .NMEM(1)
    ) i_opq_sched (
        .clk(clk), .rst_n(rst_n), .cand_vld(cand_vld), .cand_slot(cand_slot),
        .cand_age(cand_age), .cand_scalar(cand_scalar), .vrf_gnt(vrf_gnt),
        .srf_gnt(srf_gnt), .reins_vld(reins_vld), .reins_slot(reins_slot),
        .reins_age(reins_age), .reins_scalar(reins_scalar), .vrf_done(vrf_done),
        .srf_done(srf_done), .disp_ok(disp_ok), .release_vld(release_vld),
        .release_slot(release_slot), .admit(admit), .disp_vld(disp_vld),
        .disp_slot(disp_slot), .disp_age(disp_age), .disp_scalar(disp_scalar),
        .q_count(q_count), .member(member)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        cand_vld = '0; cand_slot = '0; cand_age = '0; cand_scalar = '0;
        vrf_gnt = '0; srf_gnt = '0; reins_vld = '0; reins_slot = '0;
        reins_age = '0; reins_scalar = '0; vrf_done = '0; srf_done = '0;
        disp_ok = '0; release_vld = 1'b0; release_slot = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reset_dut();
        clr();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic cand(input int r, input int sl, input int ag, input bit sc,
                        input bit vg, input bit sg);
        cand_vld[r]            = 1'b1;
        cand_slot[r*SW +: SW]  = SW'(sl);
        cand_age[r*AW +: AW]   = AW'(ag);
        cand_scalar[r]         = sc;
        vrf_gnt[r]             = vg;
        srf_gnt[r]             = sg;
    endtask

    task automatic reins(input int r, input int sl, input int ag);
        reins_vld[r]           = 1'b1;
        reins_slot[r*SW +: SW] = SW'(sl);
        reins_age[r*AW +: AW]  = AW'(ag);
        reins_scalar[r]        = 1'b0;
    endtask

    task automatic push_one(input int r, input int sl, input int ag, input bit sc);
        cand(r, sl, ag, sc, 1'b1, 1'b1);
        step();
        clr();
    endtask

    function automatic int cnt(input int r);
        return int'(q_count[r*CW +: CW]);
    endfunction

    function automatic int dslot(input int r);
        return disp_vld[r] ? int'(disp_slot[r*SW +: SW]) : -1;
    endfunction

    initial begin
        #(20ns * 200000);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        reset_dut();
        // R1 reset state
        chk("R1 count", int'(q_count), 0);
        chk("R1 disp_vld", int'(disp_vld), 0);
        chk("R1 member", int'(member), 0);

        // R2 exhaustive grant sweep on resource 2
        for (int sc = 0; sc < 2; sc++) begin
            for (int vg = 0; vg < 2; vg++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    reset_dut();
                    cand(2, 5, 1, sc[0], vg[0], sg[0]);
                    #1;
                    chk("R2 admit", int'(admit[2]), (sg == 1 && (sc == 1 || vg == 1)) ? 1 : 0);
                    step();
                    clr();
                    chk("R2 count", cnt(2), (sg == 1 && (sc == 1 || vg == 1)) ? 1 : 0);
                end
            end
        end

        // R3 / R9 membership
        reset_dut();
        push_one(2, 1, 1, 1'b0);
        chk("R3 member set", int'(member[1]), 1);
        cand(0, 1, 1, 1'b0, 1'b1, 1'b1);
        #1;
        chk("R3 member blocks", int'(admit[0]), 0);
        step();
        clr();
        srf_done[1] = 1'b1; vrf_done[1] = 1'b1; disp_ok[1] = 1'b1;
        step();
        clr();
        chk("R7 dispatch slot", dslot(2), 1);
        chk("R9 kept after dispatch", int'(member[1]), 1);
        release_vld = 1'b1; release_slot = 3'd1;
        step();
        clr();
        chk("R9 cleared by release", int'(member[1]), 0);
        cand(0, 1, 2, 1'b0, 1'b1, 1'b1);
        #1;
        chk("R3 readmit", int'(admit[0]), 1);
        step();
        clr();

        // R4 priority on a shared slot
        reset_dut();
        cand(0, 3, 1, 1'b0, 1'b1, 1'b1);
        cand(1, 3, 1, 1'b0, 1'b1, 1'b1);
        cand(2, 3, 1, 1'b0, 1'b1, 1'b1);
        #1;
        chk("R4 memory first", int'(admit), 2);
        reset_dut();
        cand(0, 3, 1, 1'b0, 1'b1, 1'b1);
        cand(2, 3, 1, 1'b0, 1'b1, 1'b1);
        #1;
        chk("R4 lower index", int'(admit), 1);
        cand(2, 4, 1, 1'b0, 1'b1, 1'b1);
        #1;
        chk("R4 distinct slots", int'(admit), 5);
        clr();

        // R5 full queue, then R6/R7 ordering
        reset_dut();
        for (int k = 0; k < 4; k++) push_one(2, k, 10 + k, 1'b0);
        chk("R5 count full", cnt(2), 4);
        cand(2, 4, 14, 1'b0, 1'b1, 1'b1);
        #1;
        chk("R5 full refuses", int'(admit[2]), 0);
        clr();
        srf_done = 8'hFF; vrf_done = 8'b0000_1100; disp_ok = 8'hFF;
        step();
        chk("R7 oldest ready", dslot(2), 2);
        chk("R7 removed", cnt(2), 3);
        step();
        chk("R7 next ready", dslot(2), 3);
        step();
        chk("R6 busy stays", int'(disp_vld[2]), 0);
        disp_ok = '0; vrf_done = 8'b0000_0001;
        step();
        chk("R7 blocked by disp_ok", int'(disp_vld[2]), 0);
        vrf_done = '0; disp_ok = 8'hFF;
        step();
        chk("R6 ready is sticky", dslot(2), 0);
        chk("R6 count", cnt(2), 1);
        clr();

        // R5 re-insert takes the last place
        reset_dut();
        for (int k = 0; k < 3; k++) push_one(2, k, 10 + k, 1'b0);
        cand(2, 5, 15, 1'b0, 1'b1, 1'b1);
        reins(2, 6, 20);
        #1;
        chk("R5 reinsert fills", int'(admit[2]), 0);
        step();
        clr();
        chk("R5 count", cnt(2), 4);

        // R7 skip a non-qualifying older entry
        reset_dut();
        push_one(2, 0, 10, 1'b0);
        push_one(2, 1, 11, 1'b0);
        srf_done = 8'hFF; vrf_done = 8'hFF; disp_ok = 8'b0000_0010;
        step();
        chk("R7 skip older", dslot(2), 1);
        disp_ok = 8'hFF;
        step();
        chk("R7 then older", dslot(2), 0);
        clr();

        // R6 scalar ignores the vector file
        reset_dut();
        cand(0, 6, 3, 1'b1, 1'b0, 1'b1);
        step();
        clr();
        srf_done[6] = 1'b1; disp_ok[6] = 1'b1;
        step();
        chk("R6 scalar ready", dslot(0), 6);
        chk("R6 scalar flag", int'(disp_scalar[0]), 1);
        clr();

        // R8 age-ordered re-insert
        reset_dut();
        push_one(2, 0, 10, 1'b0);
        push_one(2, 4, 14, 1'b0);
        reins(2, 2, 12);
        step();
        clr();
        chk("R8 count", cnt(2), 3);
        srf_done = 8'b0001_0001; vrf_done = 8'b0001_0001; disp_ok = 8'hFF;
        step();
        chk("R8 first", dslot(2), 0);
        step();
        chk("R8 middle ready", dslot(2), 2);
        step();
        chk("R8 last", dslot(2), 4);
        clr();
        reset_dut();
        push_one(2, 0, 10, 1'b0);
        reins(2, 3, 5);
        srf_done[0] = 1'b1; vrf_done[0] = 1'b1; disp_ok = 8'hFF;
        step();
        clr();
        chk("R8 before head", dslot(2), 3);
        disp_ok = 8'hFF;
        step();
        chk("R8 head follows", dslot(2), 0);
        clr();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule